// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block watches an asynchronous tamper input and, on each rising edge of it, copies the live packed-BCD calendar fields (seconds, minutes, hours, day of month, month, year) into six read-only timestamp registers. The input is brought into the clock domain by a two-flop synchronizer, and an edge detector turns each rising edge into exactly one capture request.

Every capture raises two status flags that sit in two different control registers. Software clears a flag by writing 0 to its bit. An interrupt enable turns those flags into an active-low interrupt request. A configuration register can switch the function off, or select a hold mode. In hold mode the first stored timestamp survives later events until software has cleared both flags. Otherwise each new event overwrites the stored timestamp.

A byte-wide register port gives access to the block. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `tamper_stamp`

## Requirements
- R1: After reset both flags read 0, the interrupt enable, hold-mode and disable bits read 0, all six timestamp registers read 0x00, and `irq_n` is 1.
- R2: A rising edge on `tamper_in` captures the live fields, zero-extended to a byte, into the timestamp registers. The order is 0x13 seconds (7 bits), 0x14 minutes (7), 0x15 hours (6), 0x16 day (6), 0x17 month (5), 0x18 year (8). Each edge captures once, and a level held high captures nothing further.
- R3: A capture sets bit 4 of register 0x00 and bit 5 of register 0x01.
- R4: A write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. When a capture and a clearing write fall on the same clock edge, the flag ends set.
- R5: With bit 7 of register 0x12 at 0, every accepted edge overwrites the stored timestamp, whether the flags are set or not.
- R6: With bit 7 of register 0x12 at 1, edges are ignored while either flag is set. Capture resumes once both flags are 0.
- R7: With bit 6 of register 0x12 at 1, edges cause no capture and set no flag.
- R8: `irq_n` is 0 exactly while bit 2 of register 0x01 is 1 and at least one flag is set. Otherwise it is 1.
- R9: The writable configuration bits read back as written: bit 2 of 0x01, and bits 6 and 7 of 0x12. Every other bit of 0x00, 0x01 and 0x12 reads 0, and writes to 0x13..0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_in | input | 1 | Raw tamper input |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 6 | Live hours, BCD |
| now_day | input | 6 | Live day of month, BCD |
| now_month | input | 5 | Live month, BCD, 1 to 12 |
| now_year | input | 8 | Live year, BCD |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A software write that clears a flag and a capture raised by a tamper edge can land on the same clock edge. The bench provokes this by timing the write strobe to the third clock edge after it raises `tamper_in`, which is the capture edge behind the synchronizer and edge detector. In last-event mode it judges the result by reading the flag back as still set and the timestamp as holding the new fields. The hold mode is also checked as flags are cleared one at a time: clearing one flag must not release the hold, and clearing both must.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int NFIELD = 6;

  localparam logic [AW-1:0] A_CTL1    = 8'h00;
  localparam logic [AW-1:0] A_CTL2    = 8'h01;
  localparam logic [AW-1:0] A_TSCFG   = 8'h12;
  localparam logic [AW-1:0] A_TS_BASE = 8'h13;

  localparam int B_FLAG_A = 4;
  localparam int B_FLAG_B = 5;
  localparam int B_IRQEN  = 2;
  localparam int B_OFF    = 6;
  localparam int B_HOLD   = 7;

  localparam int W_SEC = 7;
  localparam int W_MIN = 7;
  localparam int W_HR  = 6;
  localparam int W_DAY = 6;
  localparam int W_MON = 5;
  localparam int W_YR  = 8;

  typedef logic [DW-1:0] byte_t;

  function automatic int field_width(input int idx);
    case (idx)
      0: return W_SEC;
      1: return W_MIN;
      2: return W_HR;
      3: return W_DAY;
      4: return W_MON;
      default: return W_YR;
    endcase
  endfunction

  function automatic byte_t fit_field(input byte_t v, input int w);
    byte_t m;
    m = byte_t'({DW{1'b1}}) >> (DW - w);
    return v & m;
  endfunction

  function automatic logic in_ts_window(input logic [AW-1:0] a);
    return (a >= A_TS_BASE) && (a < A_TS_BASE + AW'(NFIELD));
  endfunction
endpackage

// File: rtl/tts_sync_edge.sv
module tts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= raw_in;
  end

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tts_regs.sv
module tts_regs
  import tts_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  byte_t         bus_wdata,
  output logic          cap_go,
  output logic          flag_a,
  output logic          flag_b,
  output logic          irq_en,
  output logic          ctl_hit,
  output byte_t         ctl_rdata
);
  logic hold_mode, ts_off;
  logic wr_c1, wr_c2, wr_cfg;
  logic fa_d, fb_d;
  logic unused_wbits;

  assign wr_c1  = bus_wr && (bus_addr == A_CTL1);
  assign wr_c2  = bus_wr && (bus_addr == A_CTL2);
  assign wr_cfg = bus_wr && (bus_addr == A_TSCFG);

  assign cap_go = rise && !ts_off && !(hold_mode && (flag_a || flag_b));

  always_comb begin
    fa_d = flag_a;
    fb_d = flag_b;
    if (wr_c1) fa_d = flag_a & bus_wdata[B_FLAG_A];
    if (wr_c2) fb_d = flag_b & bus_wdata[B_FLAG_B];
    if (cap_go) begin
      fa_d = 1'b1;
      fb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a    <= 1'b0;
      flag_b    <= 1'b0;
      irq_en    <= 1'b0;
      hold_mode <= 1'b0;
      ts_off    <= 1'b0;
    end else begin
      flag_a <= fa_d;
      flag_b <= fb_d;
      if (wr_c2) irq_en <= bus_wdata[B_IRQEN];
      if (wr_cfg) begin
        hold_mode <= bus_wdata[B_HOLD];
        ts_off    <= bus_wdata[B_OFF];
      end
    end
  end

  assign unused_wbits = ^{bus_wdata[1:0], bus_wdata[3]};

  always_comb begin
    ctl_rdata = '0;
    ctl_hit   = 1'b1;
    case (bus_addr)
      A_CTL1:  ctl_rdata[B_FLAG_A] = flag_a;
      A_CTL2: begin
        ctl_rdata[B_FLAG_B] = flag_b;
        ctl_rdata[B_IRQEN]  = irq_en;
      end
      A_TSCFG: begin
        ctl_rdata[B_HOLD] = hold_mode;
        ctl_rdata[B_OFF]  = ts_off;
      end
      default: ctl_hit = 1'b0;
    endcase
  end

  assert_flags_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_go |=> (flag_a && flag_b));

  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && bus_wdata[B_FLAG_A] && flag_a) |=> flag_a);

  assert_off_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_off && !flag_a) |=> !flag_a);
endmodule

// File: rtl/tts_store.sv
module tts_store
  import tts_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_go,
  input  logic [NFIELD-1:0][DW-1:0] live,
  input  logic [AW-1:0]         rd_addr,
  output logic                  ts_hit,
  output byte_t                 ts_rdata
);
  logic [NFIELD-1:0][DW-1:0] ts_q;
  logic [AW-1:0] offs;

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ts_q[g] <= '0;
        else if (cap_go) ts_q[g] <= fit_field(live[g], field_width(g));
      end
    end
  endgenerate

  assign offs   = rd_addr - A_TS_BASE;
  assign ts_hit = in_ts_window(rd_addr);

  always_comb begin
    ts_rdata = '0;
    for (int i = 0; i < NFIELD; i++)
      if (ts_hit && (offs == AW'(i))) ts_rdata = ts_q[i];
  end

  assert_no_spurious_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_go |=> $stable(ts_q));
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
  import tts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper_in,
  input  logic [W_SEC-1:0]  now_sec,
  input  logic [W_MIN-1:0]  now_min,
  input  logic [W_HR-1:0]   now_hour,
  input  logic [W_DAY-1:0]  now_day,
  input  logic [W_MON-1:0]  now_month,
  input  logic [W_YR-1:0]   now_year,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_n
);
  logic rise, cap_go, flag_a, flag_b, irq_en, ctl_hit, ts_hit;
  byte_t ctl_rdata, ts_rdata;
  logic [NFIELD-1:0][DW-1:0] live;

  assign live[0] = DW'(now_sec);
  assign live[1] = DW'(now_min);
  assign live[2] = DW'(now_hour);
  assign live[3] = DW'(now_day);
  assign live[4] = DW'(now_month);
  assign live[5] = DW'(now_year);

  tts_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(tamper_in), .rise(rise)
  );

  tts_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rise(rise), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cap_go(cap_go),
    .flag_a(flag_a), .flag_b(flag_b), .irq_en(irq_en),
    .ctl_hit(ctl_hit), .ctl_rdata(ctl_rdata)
  );

  tts_store u_store (
    .clk(clk), .rst_n(rst_n), .cap_go(cap_go), .live(live),
    .rd_addr(bus_addr), .ts_hit(ts_hit), .ts_rdata(ts_rdata)
  );

  assign bus_rdata = ctl_hit ? ctl_rdata : (ts_hit ? ts_rdata : '0);
  assign irq_n     = ~(irq_en & (flag_a | flag_b));

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_a || flag_b));

  assert_irq_follows_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_go && irq_en && !(bus_wr && bus_addr == A_CTL2)) |=> !irq_n);
endmodule

// File: tb/tb_tamper_stamp.sv
`timescale 1ns/1ps
module tb_tamper_stamp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tamper_in = 1'b0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_day = '0;
  logic [4:0] now_month = '0;
  logic [7:0] now_year = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tamper_stamp dut (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_month(now_month), .now_year(now_year),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic set_live(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                          input logic [5:0] dd, input logic [4:0] mo, input logic [7:0] y);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_day = dd; now_month = mo; now_year = y;
  endtask

  task automatic check_ts(input string req, input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] dd,
                          input logic [4:0] mo, input logic [7:0] y);
    check_reg(req, 8'h13, {1'b0, s});
    check_reg(req, 8'h14, {1'b0, m});
    check_reg(req, 8'h15, {2'b0, h});
    check_reg(req, 8'h16, {2'b0, dd});
    check_reg(req, 8'h17, {3'b0, mo});
    check_reg(req, 8'h18, y);
  endtask

  task automatic pulse;
    @(negedge clk);
    tamper_in = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tamper_in = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    check_reg("R1 ctl1", 8'h00, 8'h00);
    check_reg("R1 ctl2", 8'h01, 8'h00);
    check_reg("R1 tscfg", 8'h12, 8'h00);
    check_ts("R1 ts", 7'h0, 7'h0, 6'h0, 6'h0, 5'h0, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_basic;
    set_live(7'h59, 7'h45, 6'h23, 6'h31, 5'h12, 8'h99);
    pulse();
    check_ts("R2 capture", 7'h59, 7'h45, 6'h23, 6'h31, 5'h12, 8'h99);
    check_reg("R3 ctl1 flag", 8'h00, 8'h10);
    check_reg("R3 ctl2 flag", 8'h01, 8'h20);
    check("R8 irq disabled", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_clear;
    wr(8'h00, 8'h10);
    check_reg("R4 write1 keeps ctl1", 8'h00, 8'h10);
    wr(8'h00, 8'h00);
    check_reg("R4 clear ctl1", 8'h00, 8'h00);
    check_reg("R4 ctl2 untouched", 8'h01, 8'h20);
    wr(8'h01, 8'h20);
    check_reg("R4 write1 keeps ctl2", 8'h01, 8'h20);
    wr(8'h01, 8'h00);
    check_reg("R4 clear ctl2", 8'h01, 8'h00);
  endtask

  task automatic t_hold_level;
    set_live(7'h01, 7'h02, 6'h03, 6'h04, 5'h05, 8'h06);
    @(negedge clk);
    tamper_in = 1'b1;
    repeat (5) @(posedge clk);
    set_live(7'h11, 7'h12, 6'h13, 6'h14, 5'h09, 8'h16);
    repeat (10) @(posedge clk);
    check_ts("R2 level no recapture", 7'h01, 7'h02, 6'h03, 6'h04, 5'h05, 8'h06);
    @(negedge clk);
    tamper_in = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_last_mode;
    set_live(7'h10, 7'h20, 6'h08, 6'h15, 5'h06, 8'h24);
    pulse();
    check_ts("R5 overwrite with flags set", 7'h10, 7'h20, 6'h08, 6'h15, 5'h06, 8'h24);
    set_live(7'h33, 7'h44, 6'h12, 6'h01, 5'h01, 8'h25);
    pulse();
    check_ts("R5 second overwrite", 7'h33, 7'h44, 6'h12, 6'h01, 5'h01, 8'h25);
  endtask

  task automatic t_first_mode;
    wr(8'h12, 8'h80);
    check_reg("R9 tscfg hold", 8'h12, 8'h80);
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);
    set_live(7'h05, 7'h06, 6'h07, 6'h08, 5'h09, 8'h10);
    pulse();
    check_ts("R6 first stored", 7'h05, 7'h06, 6'h07, 6'h08, 5'h09, 8'h10);
    set_live(7'h50, 7'h51, 6'h20, 6'h21, 5'h11, 8'h30);
    pulse();
    check_ts("R6 later ignored", 7'h05, 7'h06, 6'h07, 6'h08, 5'h09, 8'h10);
    wr(8'h00, 8'h00);
    pulse();
    check_ts("R6 one flag still holds", 7'h05, 7'h06, 6'h07, 6'h08, 5'h09, 8'h10);
    check_reg("R6 ctl1 stays clear", 8'h00, 8'h00);
    wr(8'h01, 8'h00);
    pulse();
    check_ts("R6 resumes", 7'h50, 7'h51, 6'h20, 6'h21, 5'h11, 8'h30);
  endtask

  task automatic t_disable;
    wr(8'h12, 8'h40);
    check_reg("R9 tscfg off", 8'h12, 8'h40);
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);
    set_live(7'h22, 7'h23, 6'h11, 6'h12, 5'h02, 8'h77);
    pulse();
    check_ts("R7 no capture", 7'h50, 7'h51, 6'h20, 6'h21, 5'h11, 8'h30);
    check_reg("R7 no flag ctl1", 8'h00, 8'h00);
    check_reg("R7 no flag ctl2", 8'h01, 8'h00);
    wr(8'h12, 8'h00);
  endtask

  task automatic t_irq;
    wr(8'h01, 8'h04);
    check_reg("R9 irq enable readback", 8'h01, 8'h04);
    check("R8 idle high", {7'b0, irq_n}, 8'h01);
    pulse();
    check("R8 asserted", {7'b0, irq_n}, 8'h00);
    wr(8'h00, 8'h00);
    check("R8 flag_b keeps low", {7'b0, irq_n}, 8'h00);
    wr(8'h01, 8'h04);
    check("R8 released", {7'b0, irq_n}, 8'h01);
    pulse();
    wr(8'h01, 8'h20);
    check("R8 enable off", {7'b0, irq_n}, 8'h01);
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);
  endtask

  task automatic t_coincide;
    set_live(7'h40, 7'h41, 6'h02, 6'h03, 5'h04, 8'h55);
    pulse();
    set_live(7'h57, 7'h58, 6'h21, 6'h28, 5'h10, 8'h69);
    @(negedge clk);
    tamper_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    tamper_in = 1'b0;
    check_reg("R4 capture beats clear", 8'h00, 8'h10);
    check_ts("R4 coincident capture", 7'h57, 7'h58, 6'h21, 6'h28, 5'h10, 8'h69);
  endtask

  task automatic t_readonly;
    wr(8'h13, 8'h00);
    wr(8'h18, 8'h00);
    check_reg("R9 ts read-only sec", 8'h13, 8'h57);
    check_reg("R9 ts read-only yr", 8'h18, 8'h69);
    wr(8'h00, 8'hEF);
    check_reg("R9 ctl1 other bits 0", 8'h00, 8'h00);
    wr(8'h01, 8'hDB);
    check_reg("R9 ctl2 other bits 0", 8'h01, 8'h00);
    wr(8'h12, 8'h3F);
    check_reg("R9 tscfg other bits 0", 8'h12, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_hold_level();
    t_last_mode();
    t_first_mode();
    t_disable();
    t_irq();
    t_coincide();
    t_readonly();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule